// File: doc/BRIEF.md
# Shared Entry Admission Controller

This block decides whether logical threads may take entries from a pool that they share, such as the slots of a queue or a scheduler. Each thread raises an allocate request and, separately, a release pulse. In the same cycle the block answers every request with either a grant or a stall. It tracks how many entries each thread holds and how many are held in total. It does not store entry contents and does not hand out entry indices. It only performs admission control and keeps the occupancy counts.

A two-bit policy input selects how the pool is divided among the threads:

- **Split evenly:** each thread owns an equal fixed slice of the pool.
- **Capped:** all threads draw from one pool, but no thread may exceed a programmable ceiling.
- **Open:** any free entry may go to any thread.

The same counter-based decision path serves all three policies. When several threads compete for the last free entries, a rotating pointer decides which of them wins.

The reset input `rst_n` is active low and asynchronous. It is expected to be released synchronously to `clk` by the surrounding reset logic. Grants are combinational on the registered counts. Counts update at the next rising clock edge.

Top module: `shared_entry_admit`

## Requirements
- R1: With policy code 0 (split evenly), a request from a thread is stalled while that thread holds POOL/N_THREADS entries or more.
- R2: With policy code 1 (capped), a request from a thread is stalled while that thread holds at least `cap_i` entries.
- R3: In capped mode, a `cap_i` value above POOL acts as POOL.
- R4: With policy code 2 or 3 (open), no per-thread limit applies, so one thread may hold every entry of the pool.
- R5: A grant is given only for a request, and only while the total is below POOL. The total never exceeds POOL. A full pool stalls every request.
- R6: Suppose more eligible threads request than there are free entries. The free entries then go in rotating order, starting at a pointer that moves past the last winner after each such conflict. With two threads and one free entry, the winner alternates, and thread 0 wins the first conflict after reset.
- R7: A thread that is granted and releases in the same cycle keeps its count unchanged.
- R8: A release from a thread whose count is zero raises that thread's `free_err_o` bit in the same cycle and changes no count.
- R9: Changing policy removes no entries. A thread above its new limit is stalled until releases bring it below that limit, and is then granted again.
- R10: Every thread count and the total are outputs in every cycle. Thread i occupies bits [i*TOT_W +: TOT_W]. Reset clears them all to zero. A count changes at the rising edge after the grant or release that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Sharing policy: 0 split evenly, 1 capped, 2 or 3 open |
| cap_i | input | TOT_W | Per-thread ceiling used in capped mode |
| alloc_req_i | input | N_THREADS | Allocate request, one bit per thread |
| free_i | input | N_THREADS | Release one entry, one bit per thread |
| grant_o | output | N_THREADS | Request admitted this cycle |
| stall_o | output | N_THREADS | Request refused this cycle |
| free_err_o | output | N_THREADS | Release seen while the thread holds nothing |
| thread_cnt_o | output | N_THREADS*TOT_W | Per-thread occupancy, packed |
| total_cnt_o | output | TOT_W | Total occupancy |

## Verification
A wrong per-thread count or total shows up at the count outputs one edge after the grant or release that caused it. It also changes grant and stall in that same cycle on the next request that lands near a limit. So the scoreboard compares counts, grants, stalls and error flags on every cycle, rather than only at the end. A rotating pointer that is stuck or inverted does not show while requests arrive alone. It shows only on the second contested last entry, so the test makes that contest happen twice in a row. A broken limit selection shows as a grant one entry too early or too late at the exact boundary of each policy.

// File: rtl/sea_pkg.sv
package sea_pkg;
  typedef enum logic [1:0] {
    POL_SPLIT = 2'd0,
    POL_CAP   = 2'd1,
    POL_OPEN  = 2'd2,
    POL_OPEN2 = 2'd3
  } policy_e;
endpackage

// File: rtl/sea_limit.sv
module sea_limit
  import sea_pkg::*;
#(
  parameter int N_THREADS = 2,
  parameter int POOL      = 8,
  parameter int TOT_W     = $clog2(POOL + 1)
) (
  input  policy_e          pol,
  input  logic [TOT_W-1:0] cap,
  output logic [TOT_W-1:0] lim
);
  localparam int SHARE = POOL / N_THREADS;

  logic [TOT_W-1:0] cap_clamped;

  always_comb begin
    if (int'(cap) > POOL) cap_clamped = TOT_W'(POOL);
    else                  cap_clamped = cap;
  end

  always_comb begin
    unique case (pol)
      POL_SPLIT: lim = TOT_W'(SHARE);
      POL_CAP:   lim = cap_clamped;
      default:   lim = TOT_W'(POOL);
    endcase
  end
endmodule

// File: rtl/sea_thread_ctr.sv
module sea_thread_ctr #(
  parameter int TOT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             rel,
  input  logic             granted,
  input  logic [TOT_W-1:0] lim,
  output logic             cand,
  output logic             rel_ok,
  output logic             rel_err,
  output logic [TOT_W-1:0] cnt
);
  logic [TOT_W-1:0] cnt_nxt;
  logic             cnt_en;

  assign cand    = req && (cnt < lim);
  assign rel_err = rel && (cnt == '0);
  assign rel_ok  = rel && (cnt != '0);

  always_comb begin
    cnt_en  = granted ^ rel_ok;
    cnt_nxt = cnt;
    if (granted && !rel_ok)      cnt_nxt = cnt + TOT_W'(1);
    else if (!granted && rel_ok) cnt_nxt = cnt - TOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/sea_arbiter.sv
module sea_arbiter #(
  parameter int N_THREADS = 2,
  parameter int TOT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_THREADS-1:0] cand,
  input  logic [TOT_W-1:0]     room,
  output logic [N_THREADS-1:0] grant
);
  localparam int PTR_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1;

  logic [PTR_W-1:0] ptr, ptr_nxt;
  logic             ptr_en;
  logic             denied;
  int               used;
  int               last;

  always_comb begin
    grant  = '0;
    used   = 0;
    last   = int'(ptr);
    denied = 1'b0;
    for (int k = 0; k < N_THREADS; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N_THREADS;
      if (cand[idx]) begin
        if (used < int'(room)) begin
          grant[idx] = 1'b1;
          used       = used + 1;
          last       = idx;
        end else begin
          denied = 1'b1;
        end
      end
    end
    ptr_en  = denied && (|grant);
    ptr_nxt = PTR_W'((last + 1) % N_THREADS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/shared_entry_admit.sv
module shared_entry_admit
  import sea_pkg::*;
#(
  parameter int N_THREADS = 2,
  parameter int POOL      = 8,
  parameter int TOT_W     = $clog2(POOL + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 policy_i,
  input  logic [TOT_W-1:0]           cap_i,
  input  logic [N_THREADS-1:0]       alloc_req_i,
  input  logic [N_THREADS-1:0]       free_i,
  output logic [N_THREADS-1:0]       grant_o,
  output logic [N_THREADS-1:0]       stall_o,
  output logic [N_THREADS-1:0]       free_err_o,
  output logic [N_THREADS*TOT_W-1:0] thread_cnt_o,
  output logic [TOT_W-1:0]           total_cnt_o
);
  logic [TOT_W-1:0]     lim;
  logic [N_THREADS-1:0] cand;
  logic [N_THREADS-1:0] rel_ok;
  logic [TOT_W-1:0]     room;
  logic [TOT_W-1:0]     total_q, total_nxt;
  logic                 total_en;

  sea_limit #(.N_THREADS(N_THREADS), .POOL(POOL), .TOT_W(TOT_W)) u_limit (
    .pol (policy_e'(policy_i)),
    .cap (cap_i),
    .lim (lim)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    sea_thread_ctr #(.TOT_W(TOT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (alloc_req_i[t]),
      .rel     (free_i[t]),
      .granted (grant_o[t]),
      .lim     (lim),
      .cand    (cand[t]),
      .rel_ok  (rel_ok[t]),
      .rel_err (free_err_o[t]),
      .cnt     (thread_cnt_o[t*TOT_W +: TOT_W])
    );
  end

  assign room = TOT_W'(POOL) - total_q;

  sea_arbiter #(.N_THREADS(N_THREADS), .TOT_W(TOT_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .cand  (cand),
    .room  (room),
    .grant (grant_o)
  );

  assign stall_o = alloc_req_i & ~grant_o;

  always_comb begin
    int delta;
    delta = 0;
    for (int t = 0; t < N_THREADS; t++) begin
      delta = delta + int'(grant_o[t]) - int'(rel_ok[t]);
    end
    total_en  = (delta != 0);
    total_nxt = TOT_W'(int'(total_q) + delta);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total_q <= '0;
    else if (total_en) total_q <= total_nxt;
  end

  assign total_cnt_o = total_q;
endmodule

// File: rtl/sea_chk.sv
module sea_chk #(
  parameter int N_THREADS = 2,
  parameter int POOL      = 8,
  parameter int TOT_W     = $clog2(POOL + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 policy_i,
  input logic [TOT_W-1:0]           cap_i,
  input logic [N_THREADS-1:0]       alloc_req_i,
  input logic [N_THREADS-1:0]       free_i,
  input logic [N_THREADS-1:0]       grant_o,
  input logic [N_THREADS-1:0]       stall_o,
  input logic [N_THREADS-1:0]       free_err_o,
  input logic [N_THREADS*TOT_W-1:0] thread_cnt_o,
  input logic [TOT_W-1:0]           total_cnt_o
);
  localparam int SHARE = POOL / N_THREADS;

  int sum_cnt;
  always_comb begin
    sum_cnt = 0;
    for (int t = 0; t < N_THREADS; t++) sum_cnt = sum_cnt + int'(thread_cnt_o[t*TOT_W +: TOT_W]);
  end

  // R5
  total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total_cnt_o) <= POOL);

  // R10
  sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_cnt == int'(total_cnt_o));

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(total_cnt_o) == POOL) |-> (grant_o == '0));

  for (genvar t = 0; t < N_THREADS; t++) begin : g_c
    logic [TOT_W-1:0] c;
    assign c = thread_cnt_o[t*TOT_W +: TOT_W];

    // R5
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[t] |-> alloc_req_i[t]);

    // R1
    split_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'd0 && grant_o[t]) |-> (int'(c) < SHARE));

    // R2
    cap_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'd1 && grant_o[t]) |-> (int'(c) < int'(cap_i)));

    // R7
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[t] && free_i[t] && c != '0) |=> (c == $past(c)));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_err_o[t] && !grant_o[t]) |=> (c == $past(c)));
  end
endmodule

bind shared_entry_admit sea_chk #(
  .N_THREADS(N_THREADS), .POOL(POOL), .TOT_W(TOT_W)
) u_sea_chk (.*);

// File: tb/tb_shared_entry_admit.sv
module tb_shared_entry_admit;
  localparam int N  = 2;
  localparam int PL = 8;
  localparam int W  = $clog2(PL + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     policy;
  logic [W-1:0]   cap;
  logic [N-1:0]   req, fr;
  logic [N-1:0]   grant, stall, ferr;
  logic [N*W-1:0] tcnt;
  logic [W-1:0]   tot;

  shared_entry_admit #(.N_THREADS(N), .POOL(PL)) dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .cap_i(cap),
    .alloc_req_i(req), .free_i(fr), .grant_o(grant), .stall_o(stall),
    .free_err_o(ferr), .thread_cnt_o(tcnt), .total_cnt_o(tot)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [N-1:0] g;
    logic [N-1:0] s;
    logic [N-1:0] e;
    int           c0;
    int           c1;
    int           t;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  int m_cnt[N];
  int m_tot;
  int m_ptr;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lim_of();
    if (policy == 2'd0) return PL / N;
    if (policy == 2'd1) return (int'(cap) > PL) ? PL : int'(cap);
    return PL;
  endfunction

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] f, input string tag);
    exp_t e;
    bit   c0, c1;
    int   room;
    @(negedge clk);
    req = r;
    fr  = f;
    c0 = r[0] && (m_cnt[0] < lim_of());
    c1 = r[1] && (m_cnt[1] < lim_of());
    room = PL - m_tot;
    e.g = '0;
    if (c0 && c1 && room == 1) begin
      e.g[m_ptr] = 1'b1;
      m_ptr = 1 - m_ptr;
    end else if (room >= 1) begin
      e.g = {c1, c0};
    end
    e.s = r & ~e.g;
    e.e[0] = f[0] && m_cnt[0] == 0;
    e.e[1] = f[1] && m_cnt[1] == 0;
    e.c0 = m_cnt[0];
    e.c1 = m_cnt[1];
    e.t  = m_tot;
    e.tag = tag;
    q.push_back(e);
    for (int i = 0; i < N; i++) begin
      int d;
      d = int'(e.g[i]) - int'(f[i] && !e.e[i]);
      m_cnt[i] += d;
      m_tot    += d;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "grant", int'(grant), int'(e.g));
        chk(e.tag, "stall", int'(stall), int'(e.s));
        chk(e.tag, "free_err", int'(ferr), int'(e.e));
        chk(e.tag, "cnt0", int'(tcnt[0 +: W]), e.c0);
        chk(e.tag, "cnt1", int'(tcnt[W +: W]), e.c1);
        chk(e.tag, "total", int'(tot), e.t);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; policy = 2'd0; cap = '0; req = '0; fr = '0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_tot = 0; m_ptr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state seen at ports
    chk("R10 reset", "total", int'(tot), 0);
    chk("R10 reset", "tcnt", int'(tcnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 2'b00, "R10 idle after reset");
    for (int i = 0; i < 5; i++) step(2'b01, 2'b00, "R1 split t0");
    for (int i = 0; i < 5; i++) step(2'b10, 2'b00, "R1 split t1");
    step(2'b11, 2'b00, "R5 pool full");
    step(2'b00, 2'b11, "R10 release both");
    for (int i = 0; i < 3; i++) step(2'b00, 2'b01, "R10 drain t0");
    step(2'b00, 2'b01, "R8 release at zero");
    step(2'b01, 2'b00, "R10 t0 take one");
    step(2'b01, 2'b01, "R7 take and release");
    step(2'b00, 2'b00, "R7 settle");
    policy = 2'd1; cap = W'(2);
    for (int i = 0; i < 3; i++) step(2'b01, 2'b00, "R2 cap two");
    step(2'b10, 2'b00, "R2 cap t1");
    for (int i = 0; i < 3; i++) step(2'b00, 2'b10, "R8 drain t1");
    for (int i = 0; i < 2; i++) step(2'b00, 2'b01, "R10 drain t0 again");
    cap = W'(12);
    for (int i = 0; i < 9; i++) step(2'b01, 2'b00, "R3 cap clamp");
    policy = 2'd2;
    step(2'b00, 2'b01, "R4 free one");
    step(2'b11, 2'b00, "R6 conflict first");
    step(2'b00, 2'b01, "R4 free again");
    step(2'b11, 2'b00, "R6 conflict second");
    step(2'b00, 2'b01, "R4 free third");
    step(2'b11, 2'b00, "R6 conflict third");
    step(2'b00, 2'b10, "R4 t1 release");
    step(2'b01, 2'b00, "R4 t0 whole pool");
    policy = 2'd3;
    step(2'b10, 2'b00, "R4 code three full");
    policy = 2'd0;
    step(2'b01, 2'b00, "R9 over new limit");
    for (int i = 0; i < 4; i++) step(2'b01, 2'b01, "R9 stalled release");
    step(2'b01, 2'b00, "R9 at limit");
    step(2'b00, 2'b01, "R9 release below");
    step(2'b01, 2'b00, "R9 granted again");
    step(2'b00, 2'b00, "R10 final");
    @(negedge clk);
    req = '0; fr = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule